// File: doc/BRIEF.md
# DMA Request Issuer with Refusal and Retry

This block turns DMA transaction commands into a stream of memory request beats and tracks them until every byte is acknowledged. A command gives a direction (read or write), a start address, a byte count, a completion delay and a 3-bit tag chosen by the caller. The block cuts the transaction into beats of at most `MAX_BEAT` bytes. The beats go into a first-in first-out transmit queue. Only the head of that queue is offered to the memory side.

The memory side may refuse an offered beat. After a refusal the block offers nothing until a retry pulse arrives, and then it offers the same beat again. Each response carries a tag and a byte count. These bytes are added to the owning transaction's acknowledged total. When that total reaches the requested count, the transaction waits for its programmed delay and then raises a one-cycle completion pulse that carries its tag.

A pending flag shows that accepted beats are still awaiting responses. A drain request reports completion once the block has nothing left in flight or waiting to be sent.

Top module: `dma_req_issuer`

## Requirements
- R1: Beats reach the memory side in the order they were generated, and only the oldest queued beat is ever presented.
- R2: A command of N bytes at address A becomes ceil(N/64) beats (with `MAX_BEAT` = 64). Beat k has address A+64k and length 64, except the last beat, which carries the remainder. Every beat carries the command's tag and direction (`mreq_write` = 1 means write).
- R3: A cycle with `mreq_valid`=1 and `mreq_accept`=0 is a refusal. From the next cycle on, `mreq_valid` stays 0 up to and including the cycle in which `mretry` is 1. In the cycle after that, the same beat is presented again.
- R4: The outstanding count rises by one when a beat is accepted and falls by one when a response arrives. A cycle that has both leaves the count unchanged. Queued beats that have not been accepted are not counted. `pending` is 1 exactly when the count is above zero.
- R5: If a response in cycle c brings a tag's acknowledged bytes up to its requested total, `done_valid` is 1 with `done_tag` equal to that tag in cycle c+1+delay.
- R6: A zero-byte command accepted in cycle t produces no beats and completes in cycle t+1+delay.
- R7: When several tags become due for completion in the same cycle, one pulse is issued per cycle, lowest tag first. The others wait for later cycles.
- R8: `cmd_ready` is 0 while an earlier command is still being cut into beats, and also while the tag on `cmd_tag` belongs to a transaction that has not completed.
- R9: `drain_done` is 1 only while `drain_req` is 1, no accepted beat is outstanding, the transmit queue is empty and no command is still being split.
- R10: After reset, `cmd_ready`=1, and `mreq_valid`, `pending` and `done_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write transaction, 0 = read |
| cmd_tag | input | 3 | Caller-chosen transaction tag |
| cmd_addr | input | 32 | Start byte address |
| cmd_bytes | input | 16 | Transaction length in bytes |
| cmd_delay | input | 8 | Cycles between full acknowledgement and completion pulse |
| mreq_valid | output | 1 | Head beat presented to memory |
| mreq_write | output | 1 | Direction of presented beat |
| mreq_tag | output | 3 | Tag of presented beat |
| mreq_addr | output | 32 | Address of presented beat |
| mreq_len | output | 7 | Byte length of presented beat |
| mreq_accept | input | 1 | Memory takes the presented beat (0 = refusal) |
| mretry | input | 1 | Memory invites a new offer after a refusal |
| mresp_valid | input | 1 | Response arrives |
| mresp_tag | input | 3 | Tag of the responding transaction |
| mresp_len | input | 7 | Bytes acknowledged by the response |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | 3 | Tag of the completed transaction |
| pending | output | 1 | Accepted beats still awaiting responses |
| drain_req | input | 1 | Drain request |
| drain_done | output | 1 | Drain satisfied |

## Verification
Two events can update the outstanding-beat counter in the same cycle: a new beat can be accepted while an older beat's response comes back. The bench provokes this with a responder that answers after one or two cycles while further beats keep streaming, so that accepts and responses overlap in most cycles. A bench model of the outstanding count is compared with `pending` in every cycle, and the completion cycle is checked against the cycle of the final response. A second collision, where two tags become due for completion together, is set up with two back-to-back zero-byte commands whose delays cancel the one-cycle gap between them, and it is judged by the order and cycles of the two pulses.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;

    localparam int ADDR_W   = 32;
    localparam int BYTES_W  = 16;
    localparam int DLY_W    = 8;
    localparam int TAG_W    = 3;
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int MAX_BEAT = 64;
    localparam int LEN_W    = $clog2(MAX_BEAT) + 1;

    typedef struct packed {
        logic              write;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } beat_t;

    typedef struct packed {
        logic               write;
        logic [TAG_W-1:0]   tag;
        logic [ADDR_W-1:0]  addr;
        logic [BYTES_W-1:0] bytes;
        logic [DLY_W-1:0]   delay;
    } cmd_t;

    typedef enum logic [1:0] {
        TR_IDLE,
        TR_ACCUM,
        TR_WAIT
    } trk_state_e;

    // Length of the next beat given the bytes still to be split.
    function automatic logic [LEN_W-1:0] next_beat_len(input logic [BYTES_W-1:0] rem);
        if (rem > BYTES_W'(MAX_BEAT)) begin
            return LEN_W'(MAX_BEAT);
        end
        return LEN_W'(rem);
    endfunction

endpackage

// File: rtl/dmaq_splitter.sv
module dmaq_splitter
    import dmaq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  cmd_t  cmd,
    input  logic  q_full,
    output logic  push,
    output beat_t beat,
    output logic  busy
);

    logic               active;
    logic [ADDR_W-1:0]  addr_q;
    logic [BYTES_W-1:0] rem_q;
    logic [TAG_W-1:0]   tag_q;
    logic               wr_q;
    logic [LEN_W-1:0]   len_now;

    assign len_now = next_beat_len(rem_q);
    assign push    = active && !q_full;
    assign busy    = active;

    always_comb begin
        beat.write = wr_q;
        beat.tag   = tag_q;
        beat.addr  = addr_q;
        beat.len   = len_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            addr_q <= '0;
            rem_q  <= '0;
            tag_q  <= '0;
            wr_q   <= 1'b0;
        end else if (load) begin
            active <= (cmd.bytes != '0);
            addr_q <= cmd.addr;
            rem_q  <= cmd.bytes;
            tag_q  <= cmd.tag;
            wr_q   <= cmd.write;
        end else if (push) begin
            addr_q <= addr_q + ADDR_W'(len_now);
            rem_q  <= rem_q - BYTES_W'(len_now);
            if (rem_q == BYTES_W'(len_now)) begin
                active <= 1'b0;
            end
        end
    end

    // Every generated beat is non-empty and within the size limit.
    assert_beat_size_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> (beat.len != '0) && (beat.len <= LEN_W'(MAX_BEAT)));

    // The top only hands over a command while the previous one is finished.
    assert_no_load_busy_R8: assert property (@(posedge clk) disable iff (rst)
        load |-> !active);

endmodule

// File: rtl/dmaq_txq.sv
module dmaq_txq
    import dmaq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  beat_t din,
    input  logic  pop,
    output beat_t head,
    output logic  empty,
    output logic  full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    beat_t            mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] rp;
    logic [CNT_W-1:0] cnt;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign head  = mem[rp];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wp] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= ptr_inc(wp);
            if (pop)  rp <= ptr_inc(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dmaq_issue.sv
module dmaq_issue #(
    parameter int OUT_W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic q_empty,
    input  logic mreq_accept,
    input  logic mretry,
    input  logic mresp_valid,
    output logic mreq_valid,
    output logic pop,
    output logic outst_zero
);

    logic             waiting;
    logic             refused;
    logic [OUT_W-1:0] outst;

    assign mreq_valid = !q_empty && !waiting;
    assign pop        = mreq_valid && mreq_accept;
    assign refused    = mreq_valid && !mreq_accept;
    assign outst_zero = (outst == '0);

    // A refusal parks the head beat; only a retry pulse releases it.
    always_ff @(posedge clk) begin
        if (rst) begin
            waiting <= 1'b0;
        end else if (refused) begin
            waiting <= 1'b1;
        end else if (mretry) begin
            waiting <= 1'b0;
        end
    end

    // Outstanding beats: counted on acceptance, released on response.
    always_ff @(posedge clk) begin
        if (rst) begin
            outst <= '0;
        end else begin
            case ({pop, mresp_valid})
                2'b10:   outst <= outst + 1'b1;
                2'b01:   outst <= outst - 1'b1;
                default: outst <= outst;
            endcase
        end
    end

    assert_hold_after_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        refused |=> !mreq_valid);

    assert_retry_reoffers_R3: assert property (@(posedge clk) disable iff (rst)
        (waiting && mretry) |=> mreq_valid);

    assert_resp_has_owner_R4: assert property (@(posedge clk) disable iff (rst)
        mresp_valid |-> !outst_zero);

endmodule

// File: rtl/dmaq_tracker.sv
module dmaq_tracker
    import dmaq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_en,
    input  logic [TAG_W-1:0]    reg_tag,
    input  logic [BYTES_W-1:0]  reg_bytes,
    input  logic [DLY_W-1:0]    reg_delay,
    input  logic                resp_en,
    input  logic [TAG_W-1:0]    resp_tag,
    input  logic [LEN_W-1:0]    resp_len,
    output logic                done_valid,
    output logic [TAG_W-1:0]    done_tag,
    output logic [NUM_TAGS-1:0] busy
);

    localparam int SUM_W = BYTES_W + 1;

    logic [NUM_TAGS-1:0] ready_vec;

    // Lowest due tag wins the single completion slot of the cycle.
    always_comb begin
        done_valid = |ready_vec;
        done_tag   = '0;
        for (int i = NUM_TAGS - 1; i >= 0; i--) begin
            if (ready_vec[i]) done_tag = TAG_W'(i);
        end
    end

    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_slot
        trk_state_e         st;
        logic [BYTES_W-1:0] total;
        logic [BYTES_W-1:0] acked;
        logic [DLY_W-1:0]   cnt;
        logic [SUM_W-1:0]   sum;

        assign sum          = {1'b0, acked} + SUM_W'(resp_len);
        assign ready_vec[i] = (st == TR_WAIT) && (cnt == '0);
        assign busy[i]      = (st != TR_IDLE);

        always_ff @(posedge clk) begin
            if (rst) begin
                st    <= TR_IDLE;
                total <= '0;
                acked <= '0;
                cnt   <= '0;
            end else if (reg_en && (reg_tag == TAG_W'(i))) begin
                total <= reg_bytes;
                acked <= '0;
                cnt   <= reg_delay;
                st    <= (reg_bytes == '0) ? TR_WAIT : TR_ACCUM;
            end else begin
                case (st)
                    TR_ACCUM: begin
                        if (resp_en && (resp_tag == TAG_W'(i))) begin
                            acked <= sum[BYTES_W-1:0];
                            if (sum == {1'b0, total}) st <= TR_WAIT;
                        end
                    end
                    TR_WAIT: begin
                        if (cnt != '0) begin
                            cnt <= cnt - 1'b1;
                        end else if (done_tag == TAG_W'(i)) begin
                            st <= TR_IDLE;
                        end
                    end
                    default: st <= st;
                endcase
            end
        end
    end

    assert_resp_owner_R5: assert property (@(posedge clk) disable iff (rst)
        resp_en |-> busy[resp_tag]);

    assert_done_frees_R7: assert property (@(posedge clk) disable iff (rst)
        done_valid |=> !busy[$past(done_tag)]);

endmodule

// File: rtl/dma_req_issuer.sv
module dma_req_issuer
    import dmaq_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int OUT_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_write,
    input  logic [TAG_W-1:0]   cmd_tag,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [BYTES_W-1:0] cmd_bytes,
    input  logic [DLY_W-1:0]   cmd_delay,
    output logic               mreq_valid,
    output logic               mreq_write,
    output logic [TAG_W-1:0]   mreq_tag,
    output logic [ADDR_W-1:0]  mreq_addr,
    output logic [LEN_W-1:0]   mreq_len,
    input  logic               mreq_accept,
    input  logic               mretry,
    input  logic               mresp_valid,
    input  logic [TAG_W-1:0]   mresp_tag,
    input  logic [LEN_W-1:0]   mresp_len,
    output logic               done_valid,
    output logic [TAG_W-1:0]   done_tag,
    output logic               pending,
    input  logic               drain_req,
    output logic               drain_done
);

    cmd_t                cmd;
    beat_t               split_beat;
    beat_t               head;
    logic                load;
    logic                split_push;
    logic                split_busy;
    logic                q_empty;
    logic                q_full;
    logic                pop;
    logic                outst_zero;
    logic [NUM_TAGS-1:0] tag_busy;

    always_comb begin
        cmd.write = cmd_write;
        cmd.tag   = cmd_tag;
        cmd.addr  = cmd_addr;
        cmd.bytes = cmd_bytes;
        cmd.delay = cmd_delay;
    end

    assign cmd_ready = !split_busy && !tag_busy[cmd_tag];
    assign load      = cmd_valid && cmd_ready;

    dmaq_splitter u_split (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cmd    (cmd),
        .q_full (q_full),
        .push   (split_push),
        .beat   (split_beat),
        .busy   (split_busy)
    );

    dmaq_txq #(.DEPTH(FIFO_DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .push  (split_push),
        .din   (split_beat),
        .pop   (pop),
        .head  (head),
        .empty (q_empty),
        .full  (q_full)
    );

    dmaq_issue #(.OUT_W(OUT_W)) u_issue (
        .clk         (clk),
        .rst         (rst),
        .q_empty     (q_empty),
        .mreq_accept (mreq_accept),
        .mretry      (mretry),
        .mresp_valid (mresp_valid),
        .mreq_valid  (mreq_valid),
        .pop         (pop),
        .outst_zero  (outst_zero)
    );

    dmaq_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .reg_en     (load),
        .reg_tag    (cmd_tag),
        .reg_bytes  (cmd_bytes),
        .reg_delay  (cmd_delay),
        .resp_en    (mresp_valid),
        .resp_tag   (mresp_tag),
        .resp_len   (mresp_len),
        .done_valid (done_valid),
        .done_tag   (done_tag),
        .busy       (tag_busy)
    );

    assign mreq_write = head.write;
    assign mreq_tag   = head.tag;
    assign mreq_addr  = head.addr;
    assign mreq_len   = head.len;
    assign pending    = !outst_zero;
    assign drain_done = drain_req && outst_zero && q_empty && !split_busy;

endmodule

// File: tb/test_dma_req_issuer.sv
module test_dma_req_issuer;
    import dmaq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [2:0]  cmd_tag = '0;
    logic [31:0] cmd_addr = '0;
    logic [15:0] cmd_bytes = '0;
    logic [7:0]  cmd_delay = '0;
    logic        mreq_valid;
    logic        mreq_write;
    logic [2:0]  mreq_tag;
    logic [31:0] mreq_addr;
    logic [6:0]  mreq_len;
    logic        mreq_accept = 1'b0;
    logic        mretry = 1'b0;
    logic        mresp_valid = 1'b0;
    logic [2:0]  mresp_tag = '0;
    logic [6:0]  mresp_len = '0;
    logic        done_valid;
    logic [2:0]  done_tag;
    logic        pending;
    logic        drain_req = 1'b0;
    logic        drain_done;

    always #10 clk = ~clk;

    dma_req_issuer i_dma_req_issuer (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_tag(cmd_tag), .cmd_addr(cmd_addr), .cmd_bytes(cmd_bytes), .cmd_delay(cmd_delay),
        .mreq_valid(mreq_valid), .mreq_write(mreq_write), .mreq_tag(mreq_tag),
        .mreq_addr(mreq_addr), .mreq_len(mreq_len), .mreq_accept(mreq_accept),
        .mretry(mretry), .mresp_valid(mresp_valid), .mresp_tag(mresp_tag),
        .mresp_len(mresp_len), .done_valid(done_valid), .done_tag(done_tag),
        .pending(pending), .drain_req(drain_req), .drain_done(drain_done)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Responder state
    int          lat = 1;
    int          refuse_left = 0;
    bit          ref_wait = 0;
    int          retry_at = 0;
    logic [31:0] ref_addr = '0;
    int          ref_err = 0;
    int          pend_err = 0;
    int          out_model = 0;
    int          last_resp_cyc = 0;
    logic [31:0] lg_addr [256];
    int          lg_len  [256];
    int          lg_tag  [256];
    bit          lg_wr   [256];
    int          nb = 0;
    int          q_tag [$];
    int          q_len [$];
    int          q_due [$];
    int          d_tag [64];
    int          d_cyc [64];
    int          nd = 0;
    int          r_now;
    int          a_now;

    always @(negedge clk) begin
        mreq_accept = 1'b0;
        mresp_valid = 1'b0;
        mretry      = 1'b0;
        if (!rst) begin
            r_now = 0;
            a_now = 0;
            if (pending !== (out_model > 0)) pend_err++;
            if (q_due.size() > 0 && q_due[0] <= cyc) begin
                mresp_valid = 1'b1;
                mresp_tag   = 3'(q_tag.pop_front());
                mresp_len   = 7'(q_len.pop_front());
                void'(q_due.pop_front());
                last_resp_cyc = cyc;
                r_now = 1;
            end
            if (ref_wait) begin
                if (cyc <= retry_at) begin
                    if (mreq_valid) ref_err++;
                    if (cyc == retry_at) mretry = 1'b1;
                end else begin
                    if (!mreq_valid || mreq_addr != ref_addr) ref_err++;
                    ref_wait = 0;
                end
            end
            if (mreq_valid && !ref_wait) begin
                if (refuse_left > 0) begin
                    refuse_left--;
                    ref_wait = 1;
                    retry_at = cyc + 3;
                    ref_addr = mreq_addr;
                end else begin
                    mreq_accept = 1'b1;
                    a_now = 1;
                    lg_addr[nb] = mreq_addr;
                    lg_len[nb]  = int'(mreq_len);
                    lg_tag[nb]  = int'(mreq_tag);
                    lg_wr[nb]   = mreq_write;
                    nb++;
                    q_tag.push_back(int'(mreq_tag));
                    q_len.push_back(int'(mreq_len));
                    q_due.push_back(cyc + lat);
                end
            end
            out_model = out_model + a_now - r_now;
            if (done_valid) begin
                d_tag[nd] = int'(done_tag);
                d_cyc[nd] = cyc;
                nd++;
            end
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    task automatic send_cmd(input logic wr, input logic [2:0] tag, input logic [31:0] addr,
                            input logic [15:0] bytes, input logic [7:0] dly, output int acc_cyc);
        @(negedge clk);
        cmd_write = wr; cmd_tag = tag; cmd_addr = addr; cmd_bytes = bytes; cmd_delay = dly;
        cmd_valid = 1'b1;
        #1;
        while (!cmd_ready) begin
            @(negedge clk);
            #1;
        end
        acc_cyc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
    endtask

    task automatic wait_done(input int target, input int limit);
        int i = 0;
        while (nd < target && i < limit) begin
            @(negedge clk);
            i++;
        end
        #2;
        check(nd >= target, "R5 completion observed", nd, target);
    endtask

    typedef struct packed {
        logic        wr;
        logic [2:0]  tag;
        logic [31:0] addr;
        logic [15:0] bytes;
        logic [7:0]  delay;
        logic [3:0]  lat;
        logic [1:0]  nref;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1'b0, 3'd0, 32'h0000_1000, 16'd64,  8'd0, 4'd1, 2'd0},
        '{1'b1, 3'd1, 32'h0000_2004, 16'd200, 8'd2, 4'd2, 2'd0},
        '{1'b0, 3'd2, 32'h0000_3000, 16'd1,   8'd5, 4'd3, 2'd1},
        '{1'b1, 3'd3, 32'h0000_4010, 16'd130, 8'd0, 4'd1, 2'd2},
        '{1'b0, 3'd7, 32'h7FFF_FF80, 16'd128, 8'd3, 4'd4, 2'd0},
        '{1'b0, 3'd4, 32'h0000_5000, 16'd65,  8'd1, 4'd2, 2'd1},
        '{1'b1, 3'd6, 32'h0000_0600, 16'd192, 8'd0, 4'd1, 2'd0}
    };

    initial begin
        int acc;
        int nd0;
        int nb0;
        int t0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        // R10 reset state
        check(cmd_ready === 1'b1,  "R10 cmd_ready after reset", cmd_ready, 1);
        check(mreq_valid === 1'b0, "R10 mreq_valid after reset", mreq_valid, 0);
        check(pending === 1'b0,    "R10 pending after reset", pending, 0);
        check(done_valid === 1'b0, "R10 done_valid after reset", done_valid, 0);

        // Table of transactions: split, order, refusal, completion timing
        for (int v = 0; v < 7; v++) begin
            int exp_nb;
            int errs;
            int rem;
            int el;
            logic [31:0] ea;
            lat = int'(VECS[v].lat);
            refuse_left = int'(VECS[v].nref);
            ref_err = 0;
            pend_err = 0;
            nb0 = nb;
            nd0 = nd;
            send_cmd(VECS[v].wr, VECS[v].tag, VECS[v].addr, VECS[v].bytes, VECS[v].delay, acc);
            wait_done(nd0 + 1, 2000);
            exp_nb = (int'(VECS[v].bytes) + 63) / 64;
            check(nb - nb0 == exp_nb, "R2 beat count", nb - nb0, exp_nb);
            errs = 0;
            ea = VECS[v].addr;
            rem = int'(VECS[v].bytes);
            for (int k = 0; k < exp_nb && nb0 + k < nb; k++) begin
                el = (rem > 64) ? 64 : rem;
                if (lg_addr[nb0+k] != ea || lg_len[nb0+k] != el ||
                    lg_tag[nb0+k] != int'(VECS[v].tag) || lg_wr[nb0+k] != VECS[v].wr) errs++;
                ea = ea + 32'(el);
                rem = rem - el;
            end
            check(errs == 0, "R1 R2 beat order and content", errs, 0);
            check(d_tag[nd0] == int'(VECS[v].tag), "R5 done tag", d_tag[nd0], VECS[v].tag);
            check(d_cyc[nd0] == last_resp_cyc + 1 + int'(VECS[v].delay), "R5 done cycle",
                  d_cyc[nd0], last_resp_cyc + 1 + int'(VECS[v].delay));
            check(pend_err == 0, "R4 pending tracks outstanding beats", pend_err, 0);
            if (VECS[v].nref != 0) check(ref_err == 0, "R3 hold after refusal and re-offer", ref_err, 0);
        end

        // R8: ready low while splitting and while tag still live
        lat = 1;
        nd0 = nd;
        send_cmd(1'b0, 3'd1, 32'h0000_8000, 16'd192, 8'd30, acc);
        check(cmd_ready == 1'b0, "R8 ready low while splitting", cmd_ready, 0);
        repeat (12) @(negedge clk);
        #1;
        cmd_tag = 3'd1;
        #1;
        check(cmd_ready == 1'b0, "R8 ready low for live tag", cmd_ready, 0);
        cmd_tag = 3'd2;
        #1;
        check(cmd_ready == 1'b1, "R8 ready high for free tag", cmd_ready, 1);
        check(pending == 1'b0, "R4 pending clear after last response", pending, 0);
        wait_done(nd0 + 1, 200);
        check(d_cyc[nd0] == last_resp_cyc + 31, "R5 long delay", d_cyc[nd0], last_resp_cyc + 31);

        // R9: drain
        lat = 3;
        nd0 = nd;
        drain_req = 1'b1;
        send_cmd(1'b1, 3'd3, 32'h0000_9000, 16'd128, 8'd0, acc);
        check(drain_done == 1'b0, "R9 drain held while busy", drain_done, 0);
        wait_done(nd0 + 1, 200);
        check(drain_done == 1'b1, "R9 drain completes when quiet", drain_done, 1);
        drain_req = 1'b0;
        #1;
        check(drain_done == 1'b0, "R9 no drain without request", drain_done, 0);

        // R6: zero-byte command
        nb0 = nb;
        nd0 = nd;
        send_cmd(1'b0, 3'd5, 32'h0000_A000, 16'd0, 8'd3, acc);
        wait_done(nd0 + 1, 200);
        check(d_cyc[nd0] == acc + 4, "R6 zero-byte completion cycle", d_cyc[nd0], acc + 4);
        check(nb == nb0, "R6 zero-byte issues no beats", nb - nb0, 0);

        // R7: two completions due in the same cycle
        nd0 = nd;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_tag = 3'd5; cmd_bytes = 16'd0; cmd_delay = 8'd2;
        #1;
        check(cmd_ready == 1'b1, "R7 first zero-byte taken", cmd_ready, 1);
        t0 = cyc;
        @(negedge clk);
        cmd_tag = 3'd2; cmd_delay = 8'd1;
        #1;
        check(cmd_ready == 1'b1, "R7 second zero-byte taken", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_done(nd0 + 2, 200);
        check(d_tag[nd0] == 2 && d_cyc[nd0] == t0 + 3, "R7 lower tag first",
              d_tag[nd0] * 1000 + d_cyc[nd0] - t0, 2003);
        check(d_tag[nd0+1] == 5 && d_cyc[nd0+1] == t0 + 4, "R7 higher tag next cycle",
              d_tag[nd0+1] * 1000 + d_cyc[nd0+1] - t0, 5004);

        summary();
        $finish;
    end

endmodule